// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block chooses which control-store word a microcoded controller runs next. Every clock it takes the address field and the three steering bits of the microinstruction now in flight, the negative and zero flags of that microinstruction's ALU result, and the fetched opcode byte. From these it forms the next microprogram address and loads it into the microprogram counter, whose value drives the control-store read port.

A conditional branch has no target field of its own. When a selected flag test succeeds, the top address bit is forced to 1. The two outcomes therefore sit at X and X plus 0x100, and microcode places the taken path in the upper half. Multiway dispatch ORs the opcode byte into the low address bits, so each opcode value is the control-store entry point of its own microcode routine. Every routine ends by jumping back to the shared main-loop word at 0x000, which is also where a synchronous reset puts the counter. The flags are registered next to the counter so that they can be observed.

Top module: `useq_next_addr`

## Requirements
- R1: While `rst` is high at a rising edge, `mpc` becomes 0x000 and both `flag_neg` and `flag_zero` become 0, whatever the other inputs are.
- R2: When `br_on_neg`, `br_on_zero` and `op_dispatch` are all 0, `mpc` after the edge equals `nx_field` exactly.
- R3: When `br_on_neg` and `alu_neg` are both 1, bit 8 of `mpc` after the edge is 1 (field 0x080 gives 0x180).
- R4: When `br_on_zero` and `alu_zero` are both 1, bit 8 of `mpc` after the edge is 1.
- R5: When neither enabled flag test succeeds, bit 8 of `mpc` after the edge equals bit 8 of `nx_field` (field 0x080 stays 0x080).
- R6: `alu_neg` and `alu_zero` do not affect `mpc` when their enable bits are 0.
- R7: When `op_dispatch` is 1, bits 7..0 of `mpc` after the edge equal `nx_field[7:0]` OR `opcode`.
- R8: When `op_dispatch` is 0, `opcode` does not affect `mpc`.
- R9: A flag test and an opcode dispatch in the same microinstruction combine: the low bits follow R7 and bit 8 follows R3 to R5.
- R10: `flag_neg` and `flag_zero` hold, after each edge out of reset, the values that `alu_neg` and `alu_zero` had before it.
- R11: The branch mechanism only sets bit 8 and never clears it, so a field with bit 8 already set keeps it when the test fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| nx_field | input | 9 | Next-address field of the current microinstruction |
| br_on_neg | input | 1 | Enable for the branch test on the negative flag |
| br_on_zero | input | 1 | Enable for the branch test on the zero flag |
| op_dispatch | input | 1 | ORs the opcode into the low address bits |
| alu_neg | input | 1 | Negative flag of the current ALU result |
| alu_zero | input | 1 | Zero flag of the current ALU result |
| opcode | input | 8 | Fetched opcode byte |
| mpc | output | 9 | Microprogram counter; control-store read address |
| flag_neg | output | 1 | Registered negative flag |
| flag_zero | output | 1 | Registered zero flag |

## Verification
A flag branch and an opcode dispatch can be requested in the same microinstruction: the branch acts on bit 8 and the dispatch on bits 7..0 of one next address. The bench provokes this with directed words that set `op_dispatch` together with a passing or failing flag test, on fields with bit 8 clear and set. A long run of random microinstructions then mixes all steering bits. After every edge a behavioural model forms the expected address from integer masks and compares each bit of the counter with it.

// File: rtl/useq_pkg.sv
package useq_pkg;

   // Source of one low address bit
   typedef enum logic [1:0] {
      BIT_FROM_FIELD    = 2'd0,
      BIT_FROM_DISPATCH = 2'd1,
      BIT_FROM_BRANCH   = 2'd2
   } bit_src_e;

   // Steering bits taken from one microinstruction
   typedef struct packed {
      logic test_neg;
      logic test_zero;
      logic dispatch;
   } steer_t;

   // ALU condition pair
   typedef struct packed {
      logic neg;
      logic zero;
   } cond_t;

   function automatic logic branch_taken(input steer_t s, input cond_t c);
      return (s.test_neg & c.neg) | (s.test_zero & c.zero);
   endfunction

endpackage

// File: rtl/useq_cond.sv
module useq_cond
   import useq_pkg::*;
(
   input  steer_t steer,
   input  cond_t  cond,
   output logic   take
);
   always_comb take = branch_taken(steer, cond);
endmodule

// File: rtl/useq_merge.sv
module useq_merge
   import useq_pkg::*;
#(
   parameter int ADDR_W = 9,
   parameter int OPC_W  = 8
) (
   input  logic [ADDR_W-1:0] field,
   input  logic [OPC_W-1:0]  opc,
   input  logic              dispatch,
   input  logic              take,
   output logic [ADDR_W-1:0] next_addr
);
   localparam int TOP = ADDR_W - 1;

   if (OPC_W > TOP) begin : g_bad_widths
      $error("useq_merge: opcode width must leave the top address bit free");
   end

   for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
      if (i == TOP) begin : g_top
         // set-only: a taken branch forces the top bit
         always_comb next_addr[i] = field[i] | take;
      end else if (i < OPC_W) begin : g_disp
         always_comb next_addr[i] = field[i] | (dispatch & opc[i]);
      end else begin : g_pass
         always_comb next_addr[i] = field[i];
      end
   end
endmodule

// File: rtl/useq_state_reg.sv
module useq_state_reg
   import useq_pkg::*;
#(
   parameter int                ADDR_W     = 9,
   parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] d_addr,
   input  cond_t             d_cond,
   output logic [ADDR_W-1:0] q_addr,
   output cond_t             q_cond
);
   always_ff @(posedge clk) begin
      if (rst) begin
         q_addr <= RESET_ADDR;
         q_cond <= '0;
      end else begin
         q_addr <= d_addr;
         q_cond <= d_cond;
      end
   end
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
   import useq_pkg::*;
#(
   parameter int                ADDR_W     = 9,
   parameter int                OPC_W      = 8,
   parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] nx_field,
   input  logic              br_on_neg,
   input  logic              br_on_zero,
   input  logic              op_dispatch,
   input  logic              alu_neg,
   input  logic              alu_zero,
   input  logic [OPC_W-1:0]  opcode,
   output logic [ADDR_W-1:0] mpc,
   output logic              flag_neg,
   output logic              flag_zero
);
   if (ADDR_W < 2) begin : g_bad_addr
      $error("useq_next_addr: address needs at least two bits");
   end

   steer_t            steer;
   cond_t             cond_now;
   cond_t             cond_q;
   logic              take;
   logic [ADDR_W-1:0] next_addr;

   always_comb begin
      steer.test_neg  = br_on_neg;
      steer.test_zero = br_on_zero;
      steer.dispatch  = op_dispatch;
      cond_now.neg    = alu_neg;
      cond_now.zero   = alu_zero;
   end

   useq_cond u_cond (
      .steer (steer),
      .cond  (cond_now),
      .take  (take)
   );

   useq_merge #(
      .ADDR_W (ADDR_W),
      .OPC_W  (OPC_W)
   ) u_merge (
      .field     (nx_field),
      .opc       (opcode),
      .dispatch  (steer.dispatch),
      .take      (take),
      .next_addr (next_addr)
   );

   useq_state_reg #(
      .ADDR_W     (ADDR_W),
      .RESET_ADDR (RESET_ADDR)
   ) u_state (
      .clk    (clk),
      .rst    (rst),
      .d_addr (next_addr),
      .d_cond (cond_now),
      .q_addr (mpc),
      .q_cond (cond_q)
   );

   always_comb begin
      flag_neg  = cond_q.neg;
      flag_zero = cond_q.zero;
   end
endmodule

// File: rtl/useq_next_addr_chk.sv
module useq_next_addr_chk #(
   parameter int                ADDR_W     = 9,
   parameter int                OPC_W      = 8,
   parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] nx_field,
   input logic              br_on_neg,
   input logic              br_on_zero,
   input logic              op_dispatch,
   input logic              alu_neg,
   input logic              alu_zero,
   input logic [OPC_W-1:0]  opcode,
   input logic [ADDR_W-1:0] mpc,
   input logic              flag_neg,
   input logic              flag_zero
);
   localparam int TOP = ADDR_W - 1;

   logic seen = 1'b0;
   always_ff @(posedge clk) seen <= 1'b1;

   assert_reset_value_R1: assert property (@(posedge clk)
      (seen && $past(rst)) |-> (mpc == RESET_ADDR && !flag_neg && !flag_zero));

   assert_plain_follow_R2: assert property (@(posedge clk) disable iff (rst)
      (!br_on_neg && !br_on_zero && !op_dispatch) |=> (mpc == $past(nx_field)));

   assert_neg_taken_R3: assert property (@(posedge clk) disable iff (rst)
      (br_on_neg && alu_neg) |=> mpc[TOP]);

   assert_zero_taken_R4: assert property (@(posedge clk) disable iff (rst)
      (br_on_zero && alu_zero) |=> mpc[TOP]);

   assert_not_taken_R5: assert property (@(posedge clk) disable iff (rst)
      (!(br_on_neg && alu_neg) && !(br_on_zero && alu_zero))
      |=> (mpc[TOP] == $past(nx_field[TOP])));

   assert_dispatch_or_R7: assert property (@(posedge clk) disable iff (rst)
      op_dispatch |=> (mpc[OPC_W-1:0] == ($past(nx_field[OPC_W-1:0]) | $past(opcode))));

   assert_no_dispatch_R8: assert property (@(posedge clk) disable iff (rst)
      !op_dispatch |=> (mpc[OPC_W-1:0] == $past(nx_field[OPC_W-1:0])));

   assert_flag_reg_R10: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (flag_neg == $past(alu_neg) && flag_zero == $past(alu_zero)));

   assert_top_kept_R11: assert property (@(posedge clk) disable iff (rst)
      nx_field[TOP] |=> mpc[TOP]);
endmodule

bind useq_next_addr useq_next_addr_chk #(
   .ADDR_W     (ADDR_W),
   .OPC_W      (OPC_W),
   .RESET_ADDR (RESET_ADDR)
) u_chk (.*);

// File: tb/tb_useq_next_addr.sv
`timescale 1ns/1ps
module tb_useq_next_addr;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [8:0] nx_field = '0;
   logic       br_on_neg = 1'b0, br_on_zero = 1'b0, op_dispatch = 1'b0;
   logic       alu_neg = 1'b0, alu_zero = 1'b0;
   logic [7:0] opcode = '0;
   logic [8:0] mpc;
   logic       flag_neg, flag_zero;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   useq_next_addr dut (.*);

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // behavioural reference: integer masks
   function automatic int model(input int f, input bit jn, input bit jz,
                                input bit jm, input bit an, input bit az, input int op);
      int e = f;
      if (jm) e = (f & 'h100) | ((f & 'hff) | op);
      if ((jn && an) || (jz && az)) e = e | 'h100;
      return e;
   endfunction

   task automatic step(input int f, input bit jn, input bit jz, input bit jm,
                       input bit an, input bit az, input int op, input string tag);
      int e;
      @(negedge clk);
      nx_field = f[8:0]; br_on_neg = jn; br_on_zero = jz; op_dispatch = jm;
      alu_neg = an; alu_zero = az; opcode = op[7:0];
      e = model(f, jn, jz, jm, an, az, op);
      @(posedge clk); #1;
      check(tag, int'(mpc), e);
      check("R10", int'({flag_neg, flag_zero}), int'({an, az}));
   endtask

   task automatic reset_step();
      @(negedge clk);
      rst = 1'b1; nx_field = 9'h1ff; br_on_neg = 1; br_on_zero = 1; op_dispatch = 1;
      alu_neg = 1; alu_zero = 1; opcode = 8'hff;
      @(posedge clk); #1;
      check("R1", int'(mpc), 0);
      check("R1", int'({flag_neg, flag_zero}), 0);
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      #(4 * 50000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int opl[6] = '{'h57, 'h60, 'h84, 'h7e, 'h9f, 'h5f};
      reset_step();
      // R2 plain following
      step('h0a3, 0, 0, 0, 0, 0, 'h00, "R2");
      step('h1c4, 0, 0, 0, 0, 0, 'hff, "R2");
      // R6 flags without enables
      step('h080, 0, 0, 0, 1, 1, 'h00, "R6");
      // R3 / R4 taken
      step('h080, 1, 0, 0, 1, 0, 'h00, "R3");
      step('h080, 0, 1, 0, 0, 1, 'h00, "R4");
      step('h080, 1, 1, 0, 1, 1, 'h00, "R3");
      // R5 not taken
      step('h080, 1, 0, 0, 0, 1, 'h00, "R5");
      step('h080, 0, 1, 0, 1, 0, 'h00, "R5");
      // R11 top bit already set, test fails
      step('h180, 1, 1, 0, 0, 0, 'h00, "R11");
      // R7 dispatch to entry points
      foreach (opl[i]) step('h000, 0, 0, 1, 0, 0, opl[i], "R7");
      step('h101, 0, 0, 1, 0, 0, 'h60, "R7");
      // R8 opcode ignored
      step('h012, 0, 0, 0, 0, 0, 'hff, "R8");
      // R9 dispatch together with branch
      step('h000, 1, 0, 1, 1, 0, 'h84, "R9");
      step('h000, 0, 1, 1, 1, 0, 'h84, "R9");
      step('h100, 0, 1, 1, 0, 0, 'h5f, "R9");
      // reset mid-stream, then back to main loop
      reset_step();
      for (int k = 0; k < 600; k++) begin
         int  f  = int'($urandom_range(0, 511));
         bit  jn = 1'($urandom), jz = 1'($urandom), jm = 1'($urandom);
         bit  an = 1'($urandom), az = 1'($urandom);
         int  op = int'($urandom_range(0, 255));
         step(f, jn, jz, jm, an, az, op, jm ? "R9" : "R2");
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule